// File: doc/BRIEF.md
# PES scrambling control tracker

This block sits on a byte-wide transport stream of 188-byte packets. It works out, for every byte, whether the byte goes to the descrambler and with which 2-bit scrambling control value. A packet is framed by a start strobe on its first byte, and that byte must be the sync value 0x47. An external PID lookup supplies a hit flag and an entry index for the packet. The block takes both on the fourth header byte.

The block parses the packet header and skips any adaptation field. It then arbitrates between scrambling at transport level and at PES level.

- **Transport level.** This level always wins. When the packet's transport scrambling field is non-zero, the whole payload is marked with that value.
- **PES level.** This level is used only when the transport field is zero and the matched entry is flagged as carrying PES. On a packet that opens a new payload unit, the block reads the scrambling pair from the PES header and stores it for that entry. The PES header bytes pass in the clear. Later packets of the same entry reuse the stored pair.

For each packet, the first byte that is marked for descrambling carries a one-cycle re-initialise pulse, so the cipher starts fresh on every packet.

Top module: `pes_sc_tracker`

## Requirements
- R1: A packet whose start-strobe byte is not 0x47 produces no descramble enable and no re-initialise pulse on any of its bytes.
- R2: Header fields are taken from fixed byte positions counted from the sync byte as 0. The unit-start flag is byte 1 bit 6. The transport scrambling field is byte 3 bits 7:6 and the adaptation-field control is byte 3 bits 5:4. The lookup hit and index are sampled with byte 3.
- R3: With adaptation-field control 01, the payload starts at byte 4. With 11, byte 4 holds a length L and the payload starts at byte 5+L, so a start at or beyond 188 means no payload. With 00 or 10 the packet has no payload, and none of its bytes is enabled.
- R4: For a matched packet with a non-zero transport field, every payload byte is enabled with that field as the effective value and the PES-level output at 0.
- R5: A packet without a lookup hit produces no enables.
- R6: The pair in bits 5:4 of PES header byte 6 is stored for the matched entry only when all of these hold: the packet has the unit-start flag, the transport field is 00, and the entry's is-PES flag is 1. Otherwise the stored pair is left unchanged.
- R7: In a unit-start PES packet, the PES header bytes are not enabled. These are the first 9 bytes plus the count in PES header byte 8. Later payload bytes are enabled at PES level with the captured pair when that pair is non-zero.
- R8: A PES packet without the unit-start flag uses the entry's last stored pair for its whole payload.
- R9: With transport field 00, no byte is enabled when the entry's is-PES flag is 0 or its pair is 00. A byte that is not enabled shows effective value 00 and PES level 0.
- R10: The re-initialise pulse is high for exactly one byte per packet: the first enabled byte. Packets with no enabled byte give no pulse.
- R11: Every output belongs to the input byte of the previous clock cycle. The byte itself appears on the data output with its valid flag.
- R12: Reset clears every stored pair to 00 and every output to 0.
- R13: Each entry keeps its own pair, and writing one entry leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pes_flag_i | input | NUM_PID | Is-PES flag per lookup entry |
| byte_valid_i | input | 1 | Stream byte present |
| pkt_start_i | input | 1 | Marks the first byte of a packet |
| byte_i | input | 8 | Stream byte |
| match_hit_i | input | 1 | PID lookup hit, sampled on byte 3 |
| match_idx_i | input | IDX_W | Matched entry index, sampled on byte 3 |
| out_valid_o | output | 1 | Delayed byte valid |
| out_byte_o | output | 8 | Delayed stream byte |
| desc_en_o | output | 1 | Byte is to be descrambled |
| eff_sc_o | output | 2 | Effective scrambling control for the byte |
| pes_level_o | output | 1 | Enable comes from the PES level |
| reinit_o | output | 1 | Cipher re-initialise pulse |

## Verification
Some properties are checked on every cycle:
- transport-level priority over the PES level;
- the zero value shown on bytes that are not enabled;
- the pulse appearing only with an enable, and never on two bytes in a row;
- enables never appearing outside a valid output byte;
- untouched entries keeping their stored pair.

Other behaviours only show across whole packets, so only the bench scenarios can confirm them:
- where the payload starts after an adaptation field;
- where the PES header ends;
- which packets capture a pair and which leave it alone;
- reuse of a stored pair by later packets;
- rejection of a bad sync byte;
- the clearing of stored pairs by reset.

// File: rtl/pst_pkg.sv
package pst_pkg;
    localparam logic [7:0] SYNC_BYTE   = 8'h47;
    localparam logic [7:0] PKT_LEN     = 8'd188;
    localparam logic [7:0] TS_HDR_LEN  = 8'd4;
    localparam logic [7:0] PES_SC_OFF  = 8'd6;
    localparam logic [7:0] PES_LEN_OFF = 8'd8;
    localparam logic [8:0] NO_POS      = 9'h1FF;

    typedef logic [1:0] sc_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
        logic       en;
        sc_t        sc;
        logic       lvl;
        logic       reinit;
        logic       first_done;
    } out_st_t;
endpackage

// File: rtl/pst_hdr_parser.sv
module pst_hdr_parser
    import pst_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid_i,
    input  logic             pkt_start_i,
    input  logic [7:0]       byte_i,
    input  logic             match_hit_i,
    input  logic [IDX_W-1:0] match_idx_i,
    output logic             pay_o,
    output logic             body_o,
    output logic             cap_o,
    output logic             pkt_first_o,
    output sc_t              tsc_o,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic [7:0]       cnt;
        logic             act;
        logic             pusi;
        sc_t              tsc;
        logic [1:0]       afc;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [8:0]       pay_start;
        logic [8:0]       hdr_end;
    } pst_t;

    pst_t s_d, s_q;
    logic [7:0] cur;
    logic [7:0] pes_off;
    logic       cur_act;
    logic       in_pay;

    always_comb begin
        cur     = pkt_start_i ? 8'd0 : s_q.cnt;
        cur_act = byte_valid_i &&
                  (pkt_start_i ? (byte_i == SYNC_BYTE) : (s_q.act && s_q.cnt < PKT_LEN));
        in_pay  = cur_act && !pkt_start_i && cur >= TS_HDR_LEN &&
                  ({1'b0, cur} >= s_q.pay_start);
        pes_off = cur - s_q.pay_start[7:0];

        s_d = s_q;
        if (byte_valid_i) begin
            if (pkt_start_i) begin
                s_d           = '0;
                s_d.pay_start = NO_POS;
                s_d.hdr_end   = NO_POS;
                s_d.act       = cur_act;
            end
            if (pkt_start_i || s_q.cnt < PKT_LEN) begin
                s_d.cnt = cur + 8'd1;
            end
            if (cur_act && !pkt_start_i) begin
                case (cur)
                    8'd1: s_d.pusi = byte_i[6];
                    8'd3: begin
                        s_d.tsc       = byte_i[7:6];
                        s_d.afc       = byte_i[5:4];
                        s_d.hit       = match_hit_i;
                        s_d.idx       = match_idx_i;
                        s_d.pay_start = (byte_i[5:4] == 2'b01) ? {1'b0, TS_HDR_LEN} : NO_POS;
                    end
                    8'd4: begin
                        if (s_q.afc == 2'b11) begin
                            s_d.pay_start = 9'd5 + {1'b0, byte_i};
                        end
                    end
                    default: ;
                endcase
            end
            if (in_pay && s_q.pusi && pes_off == PES_LEN_OFF) begin
                s_d.hdr_end = {1'b0, cur} + 9'd1 + {1'b0, byte_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.cnt       <= PKT_LEN;
            s_q.pay_start <= NO_POS;
            s_q.hdr_end   <= NO_POS;
        end else begin
            s_q <= s_d;
        end
    end

    assign pay_o       = in_pay;
    assign body_o      = in_pay && (!s_q.pusi || ({1'b0, cur} >= s_q.hdr_end));
    assign cap_o       = in_pay && s_q.pusi && (pes_off == PES_SC_OFF);
    assign pkt_first_o = byte_valid_i && pkt_start_i;
    assign tsc_o       = s_q.tsc;
    assign hit_o       = s_q.hit;
    assign idx_o       = s_q.idx;

    // R3: a payload byte never lies inside the 4-byte transport header
    a_r3_payload_past_header: assert property (@(posedge clk) disable iff (!rst_n)
        pay_o |-> (s_q.pay_start >= {1'b0, TS_HDR_LEN}));
    // R7: a capture point is never itself a PES body byte
    a_r7_capture_in_header: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |-> !body_o);
    // R1: a dropped packet never reaches the payload stage
    a_r1_dropped_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start_i && byte_valid_i && byte_i != SYNC_BYTE) |=> !s_q.act);
endmodule

// File: rtl/pst_sc_store.sv
module pst_sc_store
    import pst_pkg::*;
#(
    parameter int NUM_PID = 4,
    parameter int IDX_W   = (NUM_PID > 1) ? $clog2(NUM_PID) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  sc_t              wsc_i,
    input  logic [IDX_W-1:0] ridx_i,
    output sc_t              rsc_o
);
    sc_t sc_d [NUM_PID];
    sc_t sc_q [NUM_PID];

    for (genvar i = 0; i < NUM_PID; i++) begin : g_entry
        always_comb begin
            sc_d[i] = sc_q[i];
            if (we_i && widx_i == IDX_W'(i)) begin
                sc_d[i] = wsc_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sc_q[i] <= 2'b00;
            end else begin
                sc_q[i] <= sc_d[i];
            end
        end

        // R13: an entry not addressed by a write keeps its pair
        a_r13_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && widx_i == IDX_W'(i)) |=> $stable(sc_q[i]));
    end

    assign rsc_o = sc_q[ridx_i];
endmodule

// File: rtl/pst_level_arb.sv
module pst_level_arb
    import pst_pkg::*;
(
    input  logic pay_i,
    input  logic body_i,
    input  logic hit_i,
    input  sc_t  tsc_i,
    input  logic pes_flag_i,
    input  sc_t  stored_sc_i,
    output logic en_o,
    output sc_t  sc_o,
    output logic lvl_pes_o
);
    logic ts_en, pes_en;

    always_comb begin
        ts_en     = pay_i && hit_i && (tsc_i != 2'b00);
        pes_en    = pay_i && body_i && hit_i && (tsc_i == 2'b00) &&
                    pes_flag_i && (stored_sc_i != 2'b00);
        en_o      = ts_en || pes_en;
        lvl_pes_o = pes_en;
        if (ts_en) begin
            sc_o = tsc_i;
        end else if (pes_en) begin
            sc_o = stored_sc_i;
        end else begin
            sc_o = 2'b00;
        end
    end
endmodule

// File: rtl/pes_sc_tracker.sv
module pes_sc_tracker
    import pst_pkg::*;
#(
    parameter int NUM_PID = 4,
    parameter int IDX_W   = (NUM_PID > 1) ? $clog2(NUM_PID) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PID-1:0] pes_flag_i,
    input  logic               byte_valid_i,
    input  logic               pkt_start_i,
    input  logic [7:0]         byte_i,
    input  logic               match_hit_i,
    input  logic [IDX_W-1:0]   match_idx_i,
    output logic               out_valid_o,
    output logic [7:0]         out_byte_o,
    output logic               desc_en_o,
    output logic [1:0]         eff_sc_o,
    output logic               pes_level_o,
    output logic               reinit_o
);
    logic             pay_w, body_w, cap_w, first_w, hit_w, flag_w, we_w, en_w, lvl_w;
    sc_t              tsc_w, st_sc_w, sc_w;
    logic [IDX_W-1:0] idx_w;
    out_st_t          r_d, r_q;

    pst_hdr_parser #(.IDX_W(IDX_W)) u_parse (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_valid_i(byte_valid_i),
        .pkt_start_i (pkt_start_i),
        .byte_i      (byte_i),
        .match_hit_i (match_hit_i),
        .match_idx_i (match_idx_i),
        .pay_o       (pay_w),
        .body_o      (body_w),
        .cap_o       (cap_w),
        .pkt_first_o (first_w),
        .tsc_o       (tsc_w),
        .hit_o       (hit_w),
        .idx_o       (idx_w)
    );

    assign flag_w = pes_flag_i[idx_w];
    assign we_w   = cap_w && hit_w && (tsc_w == 2'b00) && flag_w;

    pst_sc_store #(.NUM_PID(NUM_PID), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (we_w),
        .widx_i(idx_w),
        .wsc_i (byte_i[5:4]),
        .ridx_i(idx_w),
        .rsc_o (st_sc_w)
    );

    pst_level_arb u_arb (
        .pay_i      (pay_w),
        .body_i     (body_w),
        .hit_i      (hit_w),
        .tsc_i      (tsc_w),
        .pes_flag_i (flag_w),
        .stored_sc_i(st_sc_w),
        .en_o       (en_w),
        .sc_o       (sc_w),
        .lvl_pes_o  (lvl_w)
    );

    always_comb begin
        r_d            = r_q;
        r_d.valid      = byte_valid_i;
        r_d.data       = byte_i;
        r_d.en         = en_w;
        r_d.sc         = sc_w;
        r_d.lvl        = lvl_w;
        r_d.reinit     = en_w && !r_q.first_done;
        r_d.first_done = first_w ? 1'b0 : (r_q.first_done || en_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid_o = r_q.valid;
    assign out_byte_o  = r_q.data;
    assign desc_en_o   = r_q.en;
    assign eff_sc_o    = r_q.sc;
    assign pes_level_o = r_q.lvl;
    assign reinit_o    = r_q.reinit;

    // R4: a matched payload byte with a non-zero transport field is sent at transport level
    a_r4_ts_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_w && hit_w && tsc_w != 2'b00) |=>
        (desc_en_o && !pes_level_o && eff_sc_o == $past(tsc_w)));
    // R9: a byte that is not enabled shows a zero value and no level
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_en_o |-> (eff_sc_o == 2'b00 && !pes_level_o));
    // R7: a PES-level enable always carries a non-zero pair
    a_r7_pes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_en_o && pes_level_o) |-> (eff_sc_o != 2'b00));
    // R10: the pulse comes only with an enabled byte
    a_r10_reinit_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_o |-> desc_en_o);
    // R10: never two pulses on consecutive bytes
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_o |=> !reinit_o);
    // R11: enables only travel with a valid byte
    a_r11_en_valid: assert property (@(posedge clk) disable iff (!rst_n)
        desc_en_o |-> out_valid_o);
endmodule

// File: tb/sim_pes_sc_tracker.sv
module sim_pes_sc_tracker;
    localparam int NUM_PID = 4;
    localparam int IDX_W   = 2;
    localparam logic [NUM_PID-1:0] FLAGS = 4'b0111;

    typedef struct packed {
        logic       ok;
        logic       hit;
        logic [1:0] idx;
        logic       pusi;
        logic [1:0] tsc;
        logic [1:0] afc;
        logic [7:0] aflen;
        logic [1:0] psc;
        logic [7:0] hlen;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 2'd0, 1'b1, 2'b00, 2'b01, 8'd0,   2'b10, 8'd5},
        '{1'b1, 1'b1, 2'd0, 1'b0, 2'b00, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd0, 1'b0, 2'b11, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd1, 1'b1, 2'b00, 2'b11, 8'd7,   2'b11, 8'd0},
        '{1'b1, 1'b1, 2'd1, 1'b0, 2'b00, 2'b11, 8'd183, 2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd0, 1'b0, 2'b00, 2'b10, 8'd20,  2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd0, 1'b0, 2'b11, 2'b00, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b0, 2'd0, 1'b0, 2'b10, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd3, 1'b1, 2'b00, 2'b01, 8'd0,   2'b01, 8'd2},
        '{1'b0, 1'b1, 2'd0, 1'b0, 2'b11, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd2, 1'b1, 2'b10, 2'b01, 8'd0,   2'b01, 8'd4},
        '{1'b1, 1'b1, 2'd2, 1'b0, 2'b00, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd1, 1'b0, 2'b00, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd0, 1'b1, 2'b00, 2'b01, 8'd0,   2'b00, 8'd3},
        '{1'b1, 1'b1, 2'd0, 1'b0, 2'b00, 2'b01, 8'd0,   2'b00, 8'd0},
        '{1'b1, 1'b1, 2'd0, 1'b1, 2'b00, 2'b11, 8'd0,   2'b01, 8'd1}
    };
    localparam string TAGS [NV] = '{
        "R2 R6 R7", "R8", "R4", "R3 R6 R7", "R3", "R3", "R3", "R5",
        "R6 R9", "R1", "R4 R6", "R6 R9", "R8 R13", "R6 R9", "R8 R9", "R3 R7"
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               byte_valid = 1'b0;
    logic               pkt_start = 1'b0;
    logic [7:0]         byte_in = 8'h00;
    logic               hit_in = 1'b0;
    logic [IDX_W-1:0]   idx_in = '0;
    logic               out_valid, desc_en, pes_level, reinit;
    logic [7:0]         out_byte;
    logic [1:0]         eff_sc;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    logic [1:0] st [NUM_PID];

    always #5 clk = ~clk;

    pes_sc_tracker #(.NUM_PID(NUM_PID), .IDX_W(IDX_W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pes_flag_i  (FLAGS),
        .byte_valid_i(byte_valid),
        .pkt_start_i (pkt_start),
        .byte_i      (byte_in),
        .match_hit_i (hit_in),
        .match_idx_i (idx_in),
        .out_valid_o (out_valid),
        .out_byte_o  (out_byte),
        .desc_en_o   (desc_en),
        .eff_sc_o    (eff_sc),
        .pes_level_o (pes_level),
        .reinit_o    (reinit)
    );

    function automatic int pay_start(vec_t v);
        if (v.afc == 2'b01) return 4;
        if (v.afc == 2'b11) return 5 + int'(v.aflen);
        return 999;
    endfunction

    function automatic logic [7:0] byte_at(vec_t v, int k);
        int ps = pay_start(v);
        int o;
        if (k == 0) return v.ok ? 8'h47 : 8'h46;
        if (k == 1) return {1'b0, v.pusi, 6'h01};
        if (k == 2) return 8'h23;
        if (k == 3) return {v.tsc, v.afc, 4'h5};
        if (v.afc == 2'b11 && k == 4) return v.aflen;
        if (k < ps) return 8'hFF;
        o = k - ps;
        if (v.pusi) begin
            case (o)
                0, 1: return 8'h00;
                2: return 8'h01;
                3: return 8'hE0;
                4, 5: return 8'h00;
                6: return {2'b10, v.psc, 4'h0};
                7: return 8'h80;
                8: return v.hlen;
                default: return 8'(k);
            endcase
        end
        return 8'(k);
    endfunction

    // returns {en, sc, lvl}
    function automatic logic [3:0] expect_at(vec_t v, int k);
        int ps = pay_start(v);
        logic [1:0] s;
        if (!v.ok || !v.hit || ps > 187 || k < ps) return 4'b0;
        if (v.tsc != 2'b00) return {1'b1, v.tsc, 1'b0};
        if (!FLAGS[v.idx]) return 4'b0;
        if (v.pusi) begin
            if (k < ps + 9 + int'(v.hlen)) return 4'b0;
            s = v.psc;
        end else begin
            s = st[v.idx];
        end
        if (s == 2'b00) return 4'b0;
        return {1'b1, s, 1'b1};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_pkt(vec_t v, string tag);
        int bad_pat = -1, act_pat = 0, exp_pat = 0;
        int bad_dat = -1;
        int ri_pos = -1, ri_cnt = 0, exp_ri = -1;
        logic [3:0] e;
        for (int k = 0; k <= 188; k++) begin
            @(negedge clk);
            if (k > 0) begin
                e = expect_at(v, k - 1);
                if (e[3] && exp_ri < 0) exp_ri = k - 1;
                if ({desc_en, eff_sc, pes_level} != e && bad_pat < 0) begin
                    bad_pat = k - 1;
                    act_pat = int'({desc_en, eff_sc, pes_level});
                    exp_pat = int'(e);
                end
                if ((!out_valid || out_byte != byte_at(v, k - 1)) && bad_dat < 0) bad_dat = k - 1;
                if (reinit) begin
                    ri_cnt++;
                    if (ri_pos < 0) ri_pos = k - 1;
                end
            end
            if (k < 188) begin
                byte_valid = 1'b1;
                pkt_start  = (k == 0);
                byte_in    = byte_at(v, k);
                hit_in     = v.hit;
                idx_in     = v.idx;
            end else begin
                byte_valid = 1'b0;
                pkt_start  = 1'b0;
            end
        end
        check(bad_pat < 0, tag, $sformatf("enable/sc/level at byte %0d", bad_pat), act_pat, exp_pat);
        check(ri_pos == exp_ri && ri_cnt == (exp_ri < 0 ? 0 : 1), {tag, " R10"},
              "reinit position", ri_pos, exp_ri);
        check(bad_dat < 0, {tag, " R11"}, "delayed data mismatch at byte", bad_dat, -1);
        if (v.ok && v.hit && v.pusi && v.tsc == 2'b00 && FLAGS[v.idx] && pay_start(v) + 6 <= 187)
            st[v.idx] = v.psc;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_PID; i++) st[i] = 2'b00;
        repeat (3) @(negedge clk);
        // R12: outputs after reset
        check({out_valid, desc_en, eff_sc, pes_level, reinit} == 6'b0, "R12", "reset outputs",
              int'({out_valid, desc_en, eff_sc, pes_level, reinit}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({desc_en, reinit} == 2'b0, "R12", "idle after release", int'({desc_en, reinit}), 0);

        for (int i = 0; i < NV; i++) run_pkt(VECS[i], TAGS[i]);

        // R12: reset clears stored pairs; entry 0 then yields nothing
        rst_n = 1'b0;
        @(negedge clk);
        check({out_valid, desc_en, eff_sc, pes_level, reinit} == 6'b0, "R12", "outputs in reset",
              int'({out_valid, desc_en, eff_sc, pes_level, reinit}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NUM_PID; i++) st[i] = 2'b00;
        run_pkt('{1'b1, 1'b1, 2'd0, 1'b0, 2'b00, 2'b01, 8'd0, 2'b00, 8'd0}, "R12 R8");
        // R13: reload entry 1, then entry 2 continuation stays clear
        run_pkt('{1'b1, 1'b1, 2'd1, 1'b1, 2'b00, 2'b01, 8'd0, 2'b10, 8'd0}, "R13 R6");
        run_pkt('{1'b1, 1'b1, 2'd2, 1'b0, 2'b00, 2'b01, 8'd0, 2'b00, 8'd0}, "R13");
        run_pkt('{1'b1, 1'b1, 2'd1, 1'b0, 2'b00, 2'b01, 8'd0, 2'b00, 8'd0}, "R13 R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule